// File: doc/BRIEF.md
# Registered Input Port Selector

This block sits on the fabric side of a small controller's input path. It watches the 8-bit port address the controller presents during an input instruction and picks one of several 8-bit peripheral sources. It puts that source on the controller's input data bus through one register stage. The controller holds the address for two cycles and samples the bus on the second rising edge. The multiplexer result can therefore be registered at the first edge and still be valid in time.

One of the sources is the head of a FIFO. When the controller reads that port, the block raises a one-cycle pop request so the FIFO advances its read pointer. The request comes only with the read strobe in the second cycle, and only when the FIFO holds data. The sources sit on a contiguous, aligned address window, so indirect addressing can walk them with consecutive addresses. Only the low address bits index the window, and the remaining bits compare against a fixed base.

Top module: `inport_selector`

## Requirements
- R1: While rst_n is low, in_data reads 0x00 and fifo_pop is 0.
- R2: For a port address in the window 0x40 to 0x47, in_data after the next rising edge equals source k, where k is the low three address bits and source k occupies src_data bits [8k+7:8k]. With the address held for two cycles, the value seen in the second cycle is the one selected in the first.
- R3: An address whose upper five bits are not 01000 selects nothing, and in_data reads 0x00 one edge later.
- R4: fifo_pop is 1 in the same cycle that rd_strobe is 1, the address is 0x45 (the FIFO port, source 5) and fifo_empty is 0.
- R5: fifo_pop stays 0 whenever fifo_empty is 1, even on a strobed read of 0x45.
- R6: fifo_pop stays 0 whenever rd_strobe is 0, even with the address at 0x45 and data present.
- R7: A strobed read of any address other than 0x45 leaves fifo_pop at 0.
- R8: in_data is refreshed on every clock edge from the current address and sources, whether or not rd_strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 8 | Port address from the controller |
| rd_strobe | input | 1 | Read strobe, high in the second cycle of an input instruction |
| src_data | input | 64 | Eight packed 8-bit sources, source k in bits [8k+7:8k] |
| fifo_empty | input | 1 | Empty flag of the FIFO behind source 5 |
| in_data | output | 8 | Registered input data bus to the controller |
| fifo_pop | output | 1 | One-cycle read-pointer advance to the FIFO |

## Verification
The bench builds the block with its default parameters: eight sources, the window based at 0x40, the FIFO on source 5 and the registered output variant. With these values every low-bit index maps to a live source. Random addresses land about half inside the window, so hits on every source and misses that differ only in the upper bits both occur often. Directed cases cover the FIFO port when it is empty, the FIFO port without the strobe, and mirrors of 0x45 outside the window.

// File: rtl/inport_sel_pkg.sv
package inport_sel_pkg;
   // Output stage variant of the selector.
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/inport_addr_decode.sv
module inport_addr_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_SRC   = 8,
   parameter int SEL_W     = 3,
   parameter int BASE_ADDR = 'h40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_SRC-1:0] hit,
   output logic               any_hit
);
   localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(BASE_ADDR);
   localparam int                HI_W     = ADDR_W - SEL_W;
   localparam logic [HI_W-1:0]   BASE_TAG = BASE_V[ADDR_W-1:SEL_W];

   logic in_win;
   assign in_win = (addr[ADDR_W-1:SEL_W] == BASE_TAG);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      assign hit[i] = in_win && (addr[SEL_W-1:0] == SEL_W'(i));
   end

   assign any_hit = |hit;

   // R3: the window never selects more than one source
   assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/inport_mux_reg.sv
module inport_mux_reg
   import inport_sel_pkg::*;
#(
   parameter int        DATA_W   = 8,
   parameter int        NUM_SRC  = 8,
   parameter out_mode_e OUT_MODE = OUT_REG
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        hit,
   input  logic                      any_hit,
   input  logic [NUM_SRC*DATA_W-1:0] src,
   output logic [DATA_W-1:0]         dout
);
   logic [DATA_W-1:0] picked;

   // AND-OR tree: a miss leaves every term zero.
   always_comb begin
      picked = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         picked = picked | (src[i*DATA_W +: DATA_W] & {DATA_W{hit[i]}});
      end
   end

   if (OUT_MODE == OUT_REG) begin : g_reg
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_q <= '0;
         else        data_q <= picked;
      end
      assign dout = data_q;

      // R3: a miss in one cycle shows zero on the bus in the next
      assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !any_hit |=> (dout == '0));
   end else begin : g_comb
      assign dout = rst_n ? picked : '0;
   end
endmodule

// File: rtl/inport_pop_gen.sv
module inport_pop_gen #(
   parameter int ADDR_W    = 8,
   parameter int FIFO_ADDR = 'h45
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_strobe,
   input  logic              fifo_empty,
   output logic              pop
);
   localparam logic [ADDR_W-1:0] FIFO_A = ADDR_W'(FIFO_ADDR);

   assign pop = rst_n && rd_strobe && !fifo_empty && (addr == FIFO_A);

   // R5: never advance an empty FIFO
   assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !pop);
   // R6: the pointer only moves with the strobe
   assert_pop_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |-> !pop);
   // R7: other ports never pop
   assert_pop_only_fifo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != FIFO_A) |-> !pop);
endmodule

// File: rtl/inport_selector.sv
module inport_selector
   import inport_sel_pkg::*;
#(
   parameter int        DATA_W    = 8,
   parameter int        ADDR_W    = 8,
   parameter int        NUM_SRC   = 8,
   parameter int        BASE_ADDR = 'h40,
   parameter int        FIFO_IDX  = 5,
   parameter out_mode_e OUT_MODE  = OUT_REG
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         port_addr,
   input  logic                      rd_strobe,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   input  logic                      fifo_empty,
   output logic [DATA_W-1:0]         in_data,
   output logic                      fifo_pop
);
   localparam int SEL_W     = $clog2(NUM_SRC);
   localparam int FIFO_ADDR = BASE_ADDR + FIFO_IDX;

   if (NUM_SRC < 2 || SEL_W >= ADDR_W) begin : g_bad_count
      $error("NUM_SRC must be at least 2 and leave upper address bits");
   end
   if (FIFO_IDX < 0 || FIFO_IDX >= NUM_SRC) begin : g_bad_fifo
      $error("FIFO_IDX must name an existing source");
   end
   if ((BASE_ADDR % (1 << SEL_W)) != 0) begin : g_bad_base
      $error("BASE_ADDR must be aligned to the window size");
   end

   logic [NUM_SRC-1:0] hit;
   logic               any_hit;

   inport_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .BASE_ADDR(BASE_ADDR)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(port_addr), .hit(hit), .any_hit(any_hit)
   );

   inport_mux_reg #(
      .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .OUT_MODE(OUT_MODE)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .hit(hit), .any_hit(any_hit),
      .src(src_data), .dout(in_data)
   );

   inport_pop_gen #(
      .ADDR_W(ADDR_W), .FIFO_ADDR(FIFO_ADDR)
   ) u_pop (
      .clk(clk), .rst_n(rst_n), .addr(port_addr), .rd_strobe(rd_strobe),
      .fifo_empty(fifo_empty), .pop(fifo_pop)
   );
endmodule

// File: tb/inport_selector_test.sv
`timescale 1ns/1ps
module inport_selector_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  port_addr = 8'h00;
   logic        rd_strobe = 1'b0;
   logic [63:0] src_data = '0;
   logic        fifo_empty = 1'b1;
   logic [7:0]  in_data;
   logic        fifo_pop;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   inport_selector uut (
      .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .rd_strobe(rd_strobe),
      .src_data(src_data), .fifo_empty(fifo_empty),
      .in_data(in_data), .fifo_pop(fifo_pop)
   );

   function automatic logic [7:0] exp_data(logic [7:0] a, logic [63:0] s);
      if (a[7:3] != 5'b01000) return 8'h00;
      return s[a[2:0]*8 +: 8];
   endfunction

   function automatic logic exp_pop(logic [7:0] a, logic st, logic emp);
      return st && !emp && (a == 8'h45);
   endfunction

   task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // Two-cycle input instruction; strobe only in the second cycle.
   task automatic read_op(logic [7:0] a, logic [63:0] s, logic emp, logic strobe2);
      logic [7:0] e;
      @(negedge clk);
      port_addr = a; src_data = s; fifo_empty = emp; rd_strobe = 1'b0;
      #1;
      check(fifo_pop == 1'b0, "R6 no pop without strobe", {7'd0, fifo_pop}, 8'h00);
      e = exp_data(a, s);
      @(negedge clk);
      check(in_data == e, (a[7:3] == 5'b01000) ? "R2 selected source" : "R3 miss reads zero",
            in_data, e);
      rd_strobe = strobe2;
      #1;
      check(fifo_pop == exp_pop(a, strobe2, emp), "R4/R5/R7 pop",
            {7'd0, fifo_pop}, {7'd0, exp_pop(a, strobe2, emp)});
      @(negedge clk);
      rd_strobe = 1'b0;
      check(in_data == e, "R2 value held through second cycle", in_data, e);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=00 expected=01");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] s;
      logic [7:0]  a;
      void'($urandom(32'd1234));
      // R1: reset state
      port_addr = 8'h45; rd_strobe = 1'b1; fifo_empty = 1'b0;
      src_data = 64'hFFFF_FFFF_FFFF_FFFF;
      repeat (3) @(negedge clk);
      check(in_data == 8'h00, "R1 reset data", in_data, 8'h00);
      check(fifo_pop == 1'b0, "R1 reset pop", {7'd0, fifo_pop}, 8'h00);
      rd_strobe = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R2: every source of the window
      s = 64'h8877_6655_4433_2211;
      for (int k = 0; k < 8; k++) read_op(8'h40 + 8'(k), s, 1'b1, 1'b1);
      // R3: misses, including mirrors of the FIFO port
      read_op(8'h48, s, 1'b0, 1'b1);
      read_op(8'h38, s, 1'b0, 1'b1);
      read_op(8'hC5, s, 1'b0, 1'b1);
      read_op(8'h05, s, 1'b0, 1'b1);
      // R4 / R5 / R6 on the FIFO port
      read_op(8'h45, s, 1'b0, 1'b1);
      read_op(8'h45, s, 1'b1, 1'b1);
      read_op(8'h45, s, 1'b0, 1'b0);
      // R7: neighbour of the FIFO port
      read_op(8'h44, s, 1'b0, 1'b1);

      // R8: refresh every clock with no strobe
      for (int k = 0; k < 16; k++) begin
         logic [7:0] e;
         @(negedge clk);
         a = (k % 2 == 0) ? (8'h40 | 8'($urandom_range(0, 7))) : 8'($urandom);
         s = {$urandom, $urandom};
         port_addr = a; src_data = s; rd_strobe = 1'b0;
         e = exp_data(a, s);
         @(negedge clk);
         check(in_data == e, "R8 per-clock refresh", in_data, e);
      end

      // Constrained random instructions
      for (int n = 0; n < 300; n++) begin
         a = ($urandom_range(0, 1) == 1) ? (8'h40 | 8'($urandom_range(0, 7))) : 8'($urandom);
         s = {$urandom, $urandom};
         read_op(a, s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule